// File: doc/BRIEF.md
# Reduced Five-State Mealy Sequence Recogniser

This block is a single-input, single-output Mealy machine whose behaviour is fixed by a state table. The output `z` depends on both the present state and the live input `x`. The table was first written with seven states. It was then reduced by merging rows that have the same outputs and the same successors. The last state was folded into the fifth, and after that the sixth was folded into the fourth.

A parameter selects between the two forms. One is the reduced five-state machine, which is the intended hardware. The other is the original seven-state machine, kept so that a bench can run both side by side and show that their input-to-output behaviour is identical. A second parameter picks how the stored state is encoded: binary, Gray or one-hot. A code that matches no state is read as the start state. A three-bit state index comes out for debug, with states numbered 0..6 in table order.

Top module: `seqm_mealy_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine enters state index 0 (the start state). While it sits there, `z` is 0 for either value of `x`.
- R2: In the reduced form, the successors of each state are as follows. State 0 goes to 0 on x=0 and to 1 on x=1. State 1 goes to 2 on x=0 and to 3 on x=1. State 2 goes to 0 on x=0 and to 3 on x=1. State 3 goes to 4 on x=0 and to 3 on x=1. State 4 goes to 0 on x=0 and to 3 on x=1.
- R3: In the reduced form, `z` is 1 exactly when `x`=1 and the state index is 3 or 4. In every other case `z` is 0.
- R4: In the seven-state form, the successors are as follows. On x=0, states 0..6 go to 0,2,0,4,0,6,0. On x=1, they go to 1,3,3,5,5,5,5. `z` is 1 exactly when `x`=1 and the index is 3 or above.
- R5: For any input sequence applied after reset, the reduced and seven-state forms produce the same `z` in every cycle. The reduced index equals the seven-state index with 5 mapped to 3 and 6 mapped to 4.
- R6: The encoding parameter (0 = binary, 1 = Gray with codes i^(i>>1), 2 = one-hot with bit i set for state i) has no effect on `z` or on `state_idx`.
- R7: `state_idx` never exceeds the number of states minus one. A stored code that matches no state is decoded as state 0.
- R8: `z` follows a change of `x` within the same clock cycle, with no clock edge in between (Mealy output).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| x | input | 1 | Serial input bit, one per cycle |
| z | output | 1 | Mealy output, combinational in state and `x` |
| state_idx | output | 3 | Decoded present-state index for debug |

## Verification
The assertions check on every cycle that the index stays in range and that the stored code is a legal one. They also check that `z` is high only for `x`=1 in the output states, and that the successors taken on a 0 and on a 1 agree with the table of the selected form. The remaining behaviours are shown only by the bench. These are the full cycle-by-cycle trace against a behavioural model, the lockstep equality of `z` between the reduced and seven-state forms, the invariance across the three encodings, and the within-cycle response of `z` to `x`. The bench covers them with every six-bit sequence applied from reset, long random runs with resets in between, and a dedicated toggle of `x` in the middle of a cycle.

// File: rtl/seqm_pkg.sv
// Shared types for the Mealy sequence recogniser.
// Assumes at most eight states, so a three-bit index is enough.
package seqm_pkg;

    typedef enum logic [1:0] {
        ENC_BINARY = 2'd0,
        ENC_GRAY   = 2'd1,
        ENC_ONEHOT = 2'd2
    } seqm_enc_e;

    localparam int IDX_W = 3;
    typedef logic [IDX_W-1:0] st_idx_t;

    localparam st_idx_t ST_A = 3'd0;
    localparam st_idx_t ST_B = 3'd1;
    localparam st_idx_t ST_C = 3'd2;
    localparam st_idx_t ST_D = 3'd3;
    localparam st_idx_t ST_E = 3'd4;
    localparam st_idx_t ST_F = 3'd5;
    localparam st_idx_t ST_G = 3'd6;

endpackage

// File: rtl/seqm_table.sv
// Next-state and output table of the recogniser, in either form.
// REDUCED=1 gives the five-state table, REDUCED=0 the seven-state one.
// Assumes cur is already decoded; any out-of-range index is sent to ST_A.
module seqm_table
    import seqm_pkg::*;
#(
    parameter bit REDUCED = 1'b1
) (
    input  st_idx_t cur,
    input  logic    x,
    output st_idx_t nxt,
    output logic    z
);

    generate
        if (REDUCED) begin : g_reduced
            // Five-state successor lookup.
            always_comb begin
                unique case (cur)
                    ST_A:    nxt = x ? ST_B : ST_A;
                    ST_B:    nxt = x ? ST_D : ST_C;
                    ST_C:    nxt = x ? ST_D : ST_A;
                    ST_D:    nxt = x ? ST_D : ST_E;
                    ST_E:    nxt = x ? ST_D : ST_A;
                    default: nxt = ST_A;
                endcase
            end
            // Output is high only for a 1 in the two output states.
            always_comb begin
                z = x && ((cur == ST_D) || (cur == ST_E));
            end
        end else begin : g_full
            // Seven-state successor lookup.
            always_comb begin
                unique case (cur)
                    ST_A:    nxt = x ? ST_B : ST_A;
                    ST_B:    nxt = x ? ST_D : ST_C;
                    ST_C:    nxt = x ? ST_D : ST_A;
                    ST_D:    nxt = x ? ST_F : ST_E;
                    ST_E:    nxt = x ? ST_F : ST_A;
                    ST_F:    nxt = x ? ST_F : ST_G;
                    ST_G:    nxt = x ? ST_F : ST_A;
                    default: nxt = ST_A;
                endcase
            end
            // Output is high for a 1 in any of the four output states.
            always_comb begin
                z = x && ((cur == ST_D) || (cur == ST_E) ||
                          (cur == ST_F) || (cur == ST_G));
            end
        end
    endgenerate

endmodule

// File: rtl/seqm_codec.sv
// Maps a state index to its stored code and a stored code back to an index.
// The encoding is fixed by ENC. Codes that match no state decode to ST_A,
// with code_ok low.
module seqm_codec
    import seqm_pkg::*;
#(
    parameter seqm_enc_e ENC     = ENC_BINARY,
    parameter int        NSTATES = 5,
    parameter int        CODE_W  = 3
) (
    input  st_idx_t           idx_in,
    output logic [CODE_W-1:0] code_out,
    output logic [CODE_W-1:0] code_start,
    input  logic [CODE_W-1:0] code_in,
    output st_idx_t           idx_out,
    output logic              code_ok
);

    localparam logic [CODE_W-1:0] ONE_C = {{(CODE_W-1){1'b0}}, 1'b1};

    // Code of state i under the selected encoding.
    function automatic logic [CODE_W-1:0] enc_fn(input int i);
        logic [CODE_W-1:0] r;
        case (ENC)
            ENC_GRAY:   r = CODE_W'(i ^ (i >> 1));
            ENC_ONEHOT: r = ONE_C << i;
            default:    r = CODE_W'(i);
        endcase
        return r;
    endfunction

    // Encode the next-state index.
    always_comb begin
        code_out = enc_fn(int'(idx_in));
    end

    // Code loaded by reset.
    always_comb begin
        code_start = enc_fn(0);
    end

    // Decode the stored code; unmatched codes fall back to the start state.
    always_comb begin
        idx_out = ST_A;
        code_ok = 1'b0;
        for (int i = 0; i < NSTATES; i++) begin
            if (code_in == enc_fn(i)) begin
                idx_out = st_idx_t'(i);
                code_ok = 1'b1;
            end
        end
    end

endmodule

// File: rtl/seqm_state_reg.sv
// State code register with synchronous active-low reset to a supplied code.
module seqm_state_reg #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] rst_code,
    input  logic [CODE_W-1:0] d,
    output logic [CODE_W-1:0] q
);

    // Hold the present-state code.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= rst_code;
        else        q <= d;
    end

endmodule

// File: rtl/seqm_mealy_top.sv
// Mealy sequence recogniser with one input and one output.
// REDUCED chooses between the five-state and the seven-state table, and ENC
// chooses how the state is stored. Both forms have the same input-to-output
// behaviour. The reset is synchronous and active low.
module seqm_mealy_top
    import seqm_pkg::*;
#(
    parameter bit        REDUCED = 1'b1,
    parameter seqm_enc_e ENC     = ENC_BINARY
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       x,
    output logic       z,
    output logic [2:0] state_idx
);

    localparam int NSTATES = REDUCED ? 5 : 7;
    localparam int CODE_W  = (ENC == ENC_ONEHOT) ? NSTATES : $clog2(NSTATES);

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_d;
    logic [CODE_W-1:0] code_rst;
    st_idx_t           cur_idx;
    st_idx_t           nxt_idx;
    logic              code_ok;

    seqm_codec #(.ENC(ENC), .NSTATES(NSTATES), .CODE_W(CODE_W)) u_codec (
        .idx_in     (nxt_idx),
        .code_out   (code_d),
        .code_start (code_rst),
        .code_in    (code_q),
        .idx_out    (cur_idx),
        .code_ok    (code_ok)
    );

    seqm_table #(.REDUCED(REDUCED)) u_table (
        .cur (cur_idx),
        .x   (x),
        .nxt (nxt_idx),
        .z   (z)
    );

    seqm_state_reg #(.CODE_W(CODE_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_code (code_rst),
        .d        (code_d),
        .q        (code_q)
    );

    // Expose the decoded index for debug.
    always_comb begin
        state_idx = cur_idx;
    end

    // R7
    state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_idx < 3'(NSTATES));

    // R7
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok);

    // R3
    z_out_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z |-> (x && state_idx >= ST_D));

    // R2
    zero_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !x |=> (state_idx[0] == 1'b0));

    // R2
    start_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x && state_idx == ST_A) |=> (state_idx == ST_B));

    generate
        if (REDUCED) begin : g_red_chk
            // R2
            one_to_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (x && state_idx != ST_A) |=> (state_idx == ST_D));
        end else begin : g_full_chk
            // R4
            one_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (x && (state_idx == ST_B || state_idx == ST_C)) |=> (state_idx == ST_D));
            // R4
            one_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (x && state_idx >= ST_D) |=> (state_idx == ST_F));
        end
    endgenerate

endmodule

// File: tb/sim_seqm_mealy_top.sv
// Bench: a behavioural seven-state model, with merged indices for the
// reduced form, is compared on every cycle against five instances.
module sim_seqm_mealy_top;
    import seqm_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic x     = 1'b0;

    logic       z_rb, z_rg, z_rh, z_fb, z_fh;
    logic [2:0] s_rb, s_rg, s_rh, s_fb, s_fh;

    int checks = 0;
    int fails  = 0;
    int ref_s  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqm_mealy_top #(.REDUCED(1'b1), .ENC(ENC_BINARY)) u0 (
        .clk(clk), .rst_n(rst_n), .x(x), .z(z_rb), .state_idx(s_rb));
    seqm_mealy_top #(.REDUCED(1'b1), .ENC(ENC_GRAY)) u_rgray (
        .clk(clk), .rst_n(rst_n), .x(x), .z(z_rg), .state_idx(s_rg));
    seqm_mealy_top #(.REDUCED(1'b1), .ENC(ENC_ONEHOT)) u_rhot (
        .clk(clk), .rst_n(rst_n), .x(x), .z(z_rh), .state_idx(s_rh));
    seqm_mealy_top #(.REDUCED(1'b0), .ENC(ENC_BINARY)) u_fbin (
        .clk(clk), .rst_n(rst_n), .x(x), .z(z_fb), .state_idx(s_fb));
    seqm_mealy_top #(.REDUCED(1'b0), .ENC(ENC_ONEHOT)) u_fhot (
        .clk(clk), .rst_n(rst_n), .x(x), .z(z_fh), .state_idx(s_fh));

    // Seven-state successor model.
    function automatic int ref_next(input int s, input bit xv);
        int n0[7] = '{0, 2, 0, 4, 0, 6, 0};
        int n1[7] = '{1, 3, 3, 5, 5, 5, 5};
        return xv ? n1[s] : n0[s];
    endfunction

    // Merge map from seven-state to reduced index.
    function automatic int merged(input int s);
        if (s == 5) return 3;
        if (s == 6) return 4;
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Compare every instance with the model for the current x (called after negedge).
    task automatic compare_all();
        int ez;
        ez = (x && ref_s >= 3) ? 1 : 0;
        chk(int'(s_rb) == merged(ref_s), "R2 reduced state", int'(s_rb), merged(ref_s));
        chk(int'(z_rb) == ez, "R3 reduced z", int'(z_rb), ez);
        chk(int'(s_fb) == ref_s, "R4 full state", int'(s_fb), ref_s);
        chk(z_fb == z_rb, "R5 full vs reduced z", int'(z_fb), int'(z_rb));
        chk(int'(s_rg) == merged(ref_s) && z_rg == ez[0], "R6 gray encoding",
            int'(s_rg), merged(ref_s));
        chk(int'(s_rh) == merged(ref_s) && z_rh == ez[0], "R6 onehot encoding",
            int'(s_rh), merged(ref_s));
        chk(int'(s_fh) == ref_s && z_fh == ez[0], "R6 full onehot", int'(s_fh), ref_s);
        chk(s_rb < 3'd5 && s_fb < 3'd7, "R7 index range", int'(s_rb), 4);
    endtask

    // One cycle: drive x just after negedge, check, clock, realign at negedge.
    task automatic step(input bit xv);
        x = xv;
        #1;
        compare_all();
        @(posedge clk);
        ref_s = ref_next(ref_s, xv);
        @(negedge clk);
    endtask

    // Reset for two edges, check the start state, release at a negedge.
    task automatic do_reset();
        rst_n = 1'b0;
        x = 1'b1;
        @(posedge clk);
        @(posedge clk);
        ref_s = 0;
        #1;
        chk(s_rb == 3'd0 && s_fb == 3'd0, "R1 reset state", int'(s_rb), 0);
        chk(z_rb == 1'b0 && z_fb == 1'b0, "R1 z low in start state x=1", int'(z_rb), 0);
        x = 1'b0;
        #1;
        chk(z_rb == 1'b0, "R1 z low in start state x=0", int'(z_rb), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R8: z follows x inside one cycle while in state 3.
        step(1'b1);
        step(1'b1);
        x = 1'b0; #1;
        chk(z_rb == 1'b0, "R8 z low with x=0 in state 3", int'(z_rb), 0);
        x = 1'b1; #1;
        chk(z_rb == 1'b1 && z_fb == 1'b1, "R8 z high with x=1 same cycle", int'(z_rb), 1);
        x = 1'b0; #1;
        chk(z_rb == 1'b0, "R8 z drops with x same cycle", int'(z_rb), 0);
        step(1'b0);
        step(1'b1);

        // R5: every six-bit sequence from reset.
        for (int p = 0; p < 64; p++) begin
            do_reset();
            for (int b = 0; b < 6; b++) step(p[b]);
        end

        // R5, R6: long random runs with occasional reset.
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 199) == 0) do_reset();
            step(1'($urandom_range(0, 1)));
        end

        // Paths through the merged states: 3 -> 5 -> 6 -> 0 in the full form.
        do_reset();
        step(1'b1); step(1'b1); step(1'b1); step(1'b0); step(1'b1); step(1'b0);
        step(1'b0); step(1'b0);

        report();
        $finish;
    end

endmodule